// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a master-side sequencer. After a serial memory has received a write command, it waits until the memory has finished its internal programming cycle. The caller pulses a request together with a 7-bit target address. The block first issues the stop condition that launches the target's write cycle. Polling starts at once after that stop, with no fixed delay.

Each polling attempt is a start condition followed by the control byte, made of the address with the direction bit at 0 (write). A target that is still programming does not acknowledge this byte. After a refused attempt the block issues a stop, so that it does not hold the bus, and then tries again. When the target acknowledges, the write cycle is complete. The block then pulses done and leaves the bus open, so that the next read or write can follow within the same bus ownership.

A parameterized attempt limit bounds the loop. When the limit is reached, the block issues a final stop and pulses timeout. The block does no bit-level timing of its own. It drives a byte-level bus engine through a held command with one completion strobe per command.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `busy`, `cmdValid`, `pollDone` and `pollTimeout` are all 0.
- R2: A `reqValid` pulse while idle makes `busy` and `cmdValid` high on the next cycle, with `cmdOp` = 1 (stop).
- R3: In the cycle after the engine completes the launching stop, or a retry stop, `cmdValid` is high with `cmdOp` = 0 (start). No wait cycles are inserted.
- R4: In the cycle after a start completes, `cmdValid` is high with `cmdOp` = 2 (send byte). `cmdByte` then holds the target address in bits 7:1 and 0 in bit 0.
- R5: If a send completes with `engAck` = 0 (not acknowledged) and the attempt limit has not been reached, the next command is a stop (`cmdOp` = 1), and after it a new start.
- R6: If a send completes with `engAck` = 1, `pollDone` is high for exactly the next cycle. No stop follows, and in that cycle `busy` and `cmdValid` are 0.
- R7: When the `MAX_ATTEMPTS`-th send completes unacknowledged, one final stop is issued. When that stop completes, `pollTimeout` is high for exactly one cycle and `pollDone` stays 0.
- R8: `reqValid` is ignored while `busy` is high. The address that was captured is kept for every attempt, and no extra sequence starts.
- R9: While `cmdValid` is high and `engDone` is 0, `cmdValid`, `cmdOp` and `cmdByte` stay stable.
- R10: `pollDone` and `pollTimeout` are never high together. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a polling sequence (taken only while idle) |
| reqAddr | input | 7 | Target address |
| busy | output | 1 | Sequence in progress |
| cmdValid | output | 1 | Command to the bus engine, held until `engDone` |
| cmdOp | output | 2 | 0 start, 1 stop, 2 send byte |
| cmdByte | output | 8 | Byte to send for op 2 |
| engDone | input | 1 | Engine finished the current command (one cycle) |
| engAck | input | 1 | With `engDone` on a send: 1 means the target acknowledged |
| pollDone | output | 1 | Write cycle confirmed complete (one-cycle pulse) |
| pollTimeout | output | 1 | Attempt limit reached (one-cycle pulse) |

## Verification
A wrong state or counter shows up at the command port within one engine completion. Examples are a stop where a start belongs, a missing stop after a refusal, or a final pulse that comes one attempt early or late. The bench records every completed command and compares the whole trace with a sequence derived from the number of refusals. It also checks that each command appears in the cycle right after the previous one completes. A corrupted address register shows in the first send byte. A stray request that is taken shows as an extra or restarted sequence in the same trace.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_SEND  = 2'd2
  } busOpE;

  typedef struct packed {
    logic loadTarget;
    logic clearTries;
    logic bumpTries;
  } dpStrobeT;
endpackage

// File: rtl/ack_poll_dp.sv
module ack_poll_dp
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int MAX_ATTEMPTS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W:0]   ctrlByte,
  output logic              lastTry
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_ATTEMPTS - 1);

  logic [ADDR_W-1:0] targetQ;
  logic [CNT_W-1:0]  triesQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '0;
    end else if (strobes.loadTarget) begin
      targetQ <= reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triesQ <= '0;
    end else if (strobes.clearTries) begin
      triesQ <= '0;
    end else if (strobes.bumpTries) begin
      triesQ <= triesQ + 1'b1;
    end
  end

  // direction bit fixed at write (0)
  assign ctrlByte = {targetQ, 1'b0};
  assign lastTry  = (triesQ == LAST_IDX);
endmodule

// File: rtl/ack_poll_ctrl.sv
module ack_poll_ctrl
  import ack_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     engDone,
  input  logic     engAck,
  input  logic     lastTry,
  output dpStrobeT strobes,
  output logic     busy,
  output logic     cmdValid,
  output busOpE    cmdOp,
  output logic     pollDone,
  output logic     pollTimeout
);
  typedef enum logic [2:0] {
    S_IDLE,
    S_LAUNCH,
    S_START,
    S_SEND,
    S_RETRY,
    S_ABORT
  } stateE;

  stateE stateQ, stateD;
  logic  doneQ, timeoutQ;
  logic  sendAcked, sendRefused;

  assign sendAcked   = (stateQ == S_SEND) && engDone && engAck;
  assign sendRefused = (stateQ == S_SEND) && engDone && !engAck;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      S_IDLE:   if (reqValid) stateD = S_LAUNCH;
      S_LAUNCH: if (engDone)  stateD = S_START;
      S_START:  if (engDone)  stateD = S_SEND;
      S_SEND: begin
        if (sendAcked)                 stateD = S_IDLE;
        else if (sendRefused && lastTry) stateD = S_ABORT;
        else if (sendRefused)          stateD = S_RETRY;
      end
      S_RETRY:  if (engDone)  stateD = S_START;
      S_ABORT:  if (engDone)  stateD = S_IDLE;
      default:  stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      doneQ    <= sendAcked;
      timeoutQ <= (stateQ == S_ABORT) && engDone;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadTarget = (stateQ == S_IDLE) && reqValid;
    strobes.clearTries = (stateQ == S_IDLE) && reqValid;
    strobes.bumpTries  = sendRefused;
  end

  always_comb begin
    cmdValid = 1'b1;
    cmdOp    = OP_STOP;
    case (stateQ)
      S_LAUNCH, S_RETRY, S_ABORT: cmdOp = OP_STOP;
      S_START:                    cmdOp = OP_START;
      S_SEND:                     cmdOp = OP_SEND;
      default:                    cmdValid = 1'b0;
    endcase
  end

  assign busy        = (stateQ != S_IDLE);
  assign pollDone    = doneQ;
  assign pollTimeout = timeoutQ;
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ack_poll_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [6:0] reqAddr,
  output logic       busy,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic [7:0] cmdByte,
  input  logic       engDone,
  input  logic       engAck,
  output logic       pollDone,
  output logic       pollTimeout
);
  localparam int ADDR_W = 7;

  dpStrobeT    strobes;
  logic        lastTry;
  busOpE       opSel;
  logic [ADDR_W:0] ctrlByte;

  ack_poll_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .engDone    (engDone),
    .engAck     (engAck),
    .lastTry    (lastTry),
    .strobes    (strobes),
    .busy       (busy),
    .cmdValid   (cmdValid),
    .cmdOp      (opSel),
    .pollDone   (pollDone),
    .pollTimeout(pollTimeout)
  );

  ack_poll_dp #(
    .ADDR_W      (ADDR_W),
    .MAX_ATTEMPTS(MAX_ATTEMPTS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .ctrlByte(ctrlByte),
    .lastTry (lastTry)
  );

  assign cmdOp   = opSel;
  assign cmdByte = ctrlByte;
endmodule

// File: rtl/ack_poll_seq_chk.sv
module ack_poll_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] cmdByte,
  input logic       engDone,
  input logic       engAck,
  input logic       pollDone,
  input logic       pollTimeout
);
  // R2
  req_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (busy && cmdValid && cmdOp == 2'd1));

  // R3
  start_follows_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1 && engDone && busy) |=> (pollTimeout || (cmdValid && cmdOp == 2'd0)));

  // R4
  send_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && engDone) |=> (cmdValid && cmdOp == 2'd2 && !cmdByte[0]));

  // R6
  ack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2 && engDone && engAck) |=> (pollDone && !busy && !cmdValid));

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !engDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdByte)));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pollDone && pollTimeout));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |=> !pollDone);

  // R10
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollTimeout |=> !pollTimeout);
endmodule

bind ack_poll_seq ack_poll_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .cmdByte    (cmdByte),
  .engDone    (engDone),
  .engAck     (engAck),
  .pollDone   (pollDone),
  .pollTimeout(pollTimeout)
);

// File: tb/ack_poll_seq_bench.sv
module ack_poll_seq_bench;
  localparam int MAXA = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [6:0] reqAddr = '0;
  logic       busy, cmdValid, pollDone, pollTimeout;
  logic [1:0] cmdOp;
  logic [7:0] cmdByte;
  logic       engDone = 1'b0;
  logic       engAck = 1'b0;

  int vecCount = 0;
  int errCount = 0;

  // engine model state
  bit        engOn = 1'b0;
  int        ackOn = 0;
  int        sendsSeen = 0;
  int        waitLeft = 0;
  int        traceLen = 0;
  logic [1:0] traceOp [64];
  logic [7:0] traceByte [64];
  logic [1:0] lastOp = 2'd0;
  int        doneSeen = 0;
  int        toSeen = 0;

  always #5 clk = ~clk;

  ack_poll_seq #(.MAX_ATTEMPTS(MAXA)) u_ack_poll_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdByte(cmdByte),
    .engDone(engDone), .engAck(engAck),
    .pollDone(pollDone), .pollTimeout(pollTimeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected op at trace index for a sequence of n attempts
  function automatic logic [1:0] expOp(input int idx);
    if (idx == 0) return 2'd1;
    case ((idx - 1) % 3)
      0: return 2'd0;
      1: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic int expLen(input int ackAt);
    int n;
    n = (ackAt < MAXA) ? ackAt + 1 : MAXA;
    return (ackAt < MAXA) ? (1 + 3 * n - 1) : (1 + 3 * n);
  endfunction

  // engine model and monitors, all on the falling edge
  initial begin
    logic prevValid;
    logic [1:0] prevOp;
    logic [7:0] prevByte;
    prevValid = 1'b0; prevOp = '0; prevByte = '0;
    forever begin
      @(negedge clk);
      if (engOn) begin
        if (pollDone) doneSeen++;
        if (pollTimeout) toSeen++;
        // R9 hold
        if (prevValid && !engDone)
          check(cmdValid && cmdOp == prevOp && cmdByte == prevByte, "R9",
                {cmdValid, cmdOp}, {1'b1, prevOp});
        if (engDone) begin
          engDone = 1'b0;
          // R3 / R5 / R4 next command immediately
          if (lastOp == 2'd1 && !pollTimeout)
            check(cmdValid && cmdOp == 2'd0, "R3", {cmdValid, cmdOp}, 3'b100);
          if (lastOp == 2'd0)
            check(cmdValid && cmdOp == 2'd2, "R4", {cmdValid, cmdOp}, 3'b110);
          if (lastOp == 2'd2 && !pollDone)
            check(cmdValid && cmdOp == 2'd1, "R5", {cmdValid, cmdOp}, 3'b101);
          if (lastOp == 2'd2 && pollDone)
            check(!cmdValid && !busy, "R6", {cmdValid, busy}, 0);
        end else if (cmdValid) begin
          if (waitLeft > 0) waitLeft--;
          else begin
            engDone = 1'b1;
            lastOp = cmdOp;
            if (traceLen < 64) begin
              traceOp[traceLen] = cmdOp;
              traceByte[traceLen] = cmdByte;
            end
            traceLen++;
            if (cmdOp == 2'd2) begin
              engAck = (sendsSeen == ackOn);
              sendsSeen++;
            end
            waitLeft = $urandom % 3;
          end
        end
      end
      prevValid = cmdValid && !engDone;
      prevOp = cmdOp;
      prevByte = cmdByte;
    end
  end

  task automatic runPoll(input logic [6:0] addr, input int ackAt, input bit stray);
    int cyc;
    ackOn = ackAt; sendsSeen = 0; traceLen = 0; doneSeen = 0; toSeen = 0;
    waitLeft = $urandom % 3; lastOp = 2'd3; engOn = 1'b1;
    @(negedge clk);
    reqAddr = addr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R2
    check(busy && cmdValid && cmdOp == 2'd1, "R2", {busy, cmdValid, cmdOp}, 4'b1101);
    if (stray) begin
      @(negedge clk);
      reqAddr = addr ^ 7'h55; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    cyc = 0;
    while (!(pollDone || pollTimeout) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 2000, "watchdog", cyc, 2000);
    repeat (4) @(negedge clk);
    engOn = 1'b0;
    // R8: no restart after completion
    check(!busy && !cmdValid, "R8", {busy, cmdValid}, 0);
    check(traceLen == expLen(ackAt), (ackAt < MAXA) ? "R5" : "R7", traceLen, expLen(ackAt));
    for (int i = 0; i < traceLen && i < 64; i++) begin
      check(traceOp[i] == expOp(i), (ackAt < MAXA) ? "R5" : "R7", traceOp[i], expOp(i));
      if (traceOp[i] == 2'd2)
        check(traceByte[i] == {addr, 1'b0}, stray ? "R8" : "R4", traceByte[i], {addr, 1'b0});
    end
    if (ackAt < MAXA) begin
      check(doneSeen == 1 && toSeen == 0, "R6", doneSeen * 10 + toSeen, 10);
    end else begin
      check(toSeen == 1 && doneSeen == 0, "R7", doneSeen * 10 + toSeen, 1);
    end
    check(doneSeen + toSeen == 1, "R10", doneSeen + toSeen, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !cmdValid && !pollDone && !pollTimeout, "R1",
          {busy, cmdValid, pollDone, pollTimeout}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cmdValid, "R1", {busy, cmdValid}, 0);
    // directed corners
    runPoll(7'h50, 0, 1'b0);          // immediate ack
    runPoll(7'h7F, 1, 1'b1);          // one refusal, stray request
    runPoll(7'h00, MAXA - 1, 1'b0);   // ack on last allowed attempt
    runPoll(7'h2A, MAXA, 1'b1);       // timeout
    runPoll(7'h13, 50, 1'b0);         // never acks
    // random
    for (int k = 0; k < 20; k++)
      runPoll(7'($urandom), int'($urandom % (MAXA + 3)), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule